// File: doc/BRIEF.md
# Fast Slew Edge Accelerator

This block shortens each edge of a relaxation oscillator. After every transition of the oscillator output, it holds the oscillator's 2-bit current-range control at its largest code for a programmed number of fast-clock periods. It then hands control back to the range value software chose. Software sets the interval and an enable through an 8-bit control register. It sets its preferred current range through a second register. Both registers sit on a simple single-cycle write and combinational read bus.

The oscillator output is asynchronous to the fast clock. It is brought in through a flop synchroniser. A change in either direction produces a one-cycle reload pulse. That pulse restarts a down-counter from the programmed interval. While the counter is nonzero and the enable is set, the range output is forced high. Readback of the range register always shows the value software wrote.

Top module: `fast_slew_ctrl`

## Requirements
- R1: After reset, both registers read 0x00 and `range_eff` is 2'b00.
- R2: Address 0 is the control register: bits 7:1 are the interval count N, bit 0 is the enable. Both are writable and read back as written. Address 1 is the range register: bits 1:0 hold the user range, and bits 7:2 read as zero.
- R3: With the enable set and N>0, a rising edge of `osc_in` forces `range_eff` to 2'b11. The override begins after the third rising clock edge following the change and lasts exactly N clock periods.
- R4: A falling edge of `osc_in` starts the same override as a rising edge.
- R5: When the countdown reaches zero, `range_eff` returns to the user range.
- R6: With N=0, no override happens on an oscillator edge.
- R7: With the enable clear, `range_eff` equals the user range whatever N holds and however `osc_in` toggles.
- R8: Reading the range register during an override returns the user value, not 2'b11.
- R9: An oscillator edge during an active override reloads the counter to the full N. The override then lasts N periods from that reload; the new count is not added to what remained.
- R10: Clearing the enable during an override releases `range_eff` from the clock edge of the write and clears the counter. Setting the enable again without a new edge brings no override.
- R11: Writing a new N during an override leaves that override's length unchanged. The next oscillator edge uses the new N.
- R12: The largest count, N=127, gives an override of 127 clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for the counter and registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Register select: 0 control, 1 range |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| osc_in | input | 1 | Relaxation oscillator output, asynchronous |
| range_eff | output | 2 | Effective current range sent to the oscillator |

## Verification
An oscillator change lands on the third rising clock edge after it: two synchroniser flops, then the counter load. The first forced sample is therefore due at the third falling edge after the toggle, and the override lasts N falling-edge samples. A register write takes effect at the rising edge that samples the strobe, so readback and the release on disable are checked at the following falling edge. The bench applies every toggle and write just after a falling edge and reads outputs only on falling edges. It counts those samples against the expected first index and length, so each check sits a fixed number of half periods away from the register that feeds it.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
   typedef enum logic {
      REG_CTRL  = 1'b0,
      REG_RANGE = 1'b1
   } fsc_reg_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/fsc_regs.sv
module fsc_regs
   import fsc_pkg::*;
#(
   parameter int unsigned CNT_W   = 7,
   parameter int unsigned RANGE_W = 2,
   localparam int unsigned DATA_W = CNT_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [CNT_W-1:0]   cnt_cfg,
   output logic               fs_en,
   output logic [RANGE_W-1:0] user_range
);
   fsc_reg_e sel;
   assign sel = fsc_reg_e'(bus_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_cfg <= '0;
         fs_en   <= 1'b0;
      end else if (bus_wr && sel == REG_CTRL) begin
         cnt_cfg <= bus_wdata[DATA_W-1:1];
         fs_en   <= bus_wdata[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         user_range <= '0;
      end else if (bus_wr && sel == REG_RANGE) begin
         user_range <= bus_wdata[RANGE_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (sel)
         REG_CTRL:  bus_rdata = {cnt_cfg, fs_en};
         REG_RANGE: bus_rdata[RANGE_W-1:0] = user_range;
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/fsc_edge_sync.sv
module fsc_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic edge_pulse
);
   logic [STAGES:0] chain;

   for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign edge_pulse = chain[STAGES-1] ^ chain[STAGES];
endmodule

// File: rtl/fsc_countdown.sv
module fsc_countdown #(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             reload,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             active
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              count <= '0;
      else if (!enable)        count <= '0;
      else if (reload)         count <= load_val;
      else if (count != '0)    count <= count - 1'b1;
   end

   assign active = (count != '0);
endmodule

// File: rtl/fast_slew_ctrl.sv
module fast_slew_ctrl #(
   parameter int unsigned CNT_W       = 7,
   parameter int unsigned RANGE_W     = 2,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned DATA_W     = CNT_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               osc_in,
   output logic [RANGE_W-1:0] range_eff
);
   if (SYNC_STAGES < fsc_pkg::MIN_SYNC_STAGES) begin : g_bad_sync
      $error("fast_slew_ctrl: SYNC_STAGES below minimum");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("fast_slew_ctrl: CNT_W must be at least 1");
   end
   if (RANGE_W < 1 || RANGE_W > DATA_W) begin : g_bad_range
      $error("fast_slew_ctrl: RANGE_W out of range");
   end

   logic [CNT_W-1:0]   cnt_cfg;
   logic               fs_en;
   logic [RANGE_W-1:0] user_range;
   logic               reload;
   logic [CNT_W-1:0]   count;
   logic               active;

   fsc_regs #(.CNT_W(CNT_W), .RANGE_W(RANGE_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .cnt_cfg    (cnt_cfg),
      .fs_en      (fs_en),
      .user_range (user_range)
   );

   fsc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   (osc_in),
      .edge_pulse (reload)
   );

   fsc_countdown #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (fs_en),
      .reload   (reload),
      .load_val (cnt_cfg),
      .count    (count),
      .active   (active)
   );

   assign range_eff = (fs_en && active) ? {RANGE_W{1'b1}} : user_range;
endmodule

// File: rtl/fsc_chk.sv
module fsc_chk #(
   parameter int unsigned CNT_W   = 7,
   parameter int unsigned RANGE_W = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               fs_en,
   input logic [CNT_W-1:0]   cnt_cfg,
   input logic [RANGE_W-1:0] user_range,
   input logic               reload,
   input logic [CNT_W-1:0]   count,
   input logic [RANGE_W-1:0] range_eff
);
   // R7
   disabled_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fs_en |-> range_eff == user_range);

   // R3
   override_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      range_eff != user_range |-> range_eff == {RANGE_W{1'b1}});

   // R9
   reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload && fs_en |=> count == $past(cnt_cfg) || !fs_en);

   // R5
   countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fs_en && !reload && count != '0 |=> count == CNT_W'($past(count) - 1'b1) || count == '0);

   // R10
   disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fs_en |=> count == '0 || reload);

   // R6
   zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload && fs_en && cnt_cfg == '0 |=> count == '0);
endmodule

bind fast_slew_ctrl fsc_chk #(.CNT_W(CNT_W), .RANGE_W(RANGE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fs_en      (fs_en),
   .cnt_cfg    (cnt_cfg),
   .user_range (user_range),
   .reload     (reload),
   .count      (count),
   .range_eff  (range_eff)
);

// File: tb/tb_fast_slew_ctrl.sv
`timescale 1ns/1ps
module tb_fast_slew_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_addr = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       osc_in = 1'b0;
   logic [1:0] range_eff;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   localparam logic [1:0] USR = 2'b01;

   always #4 clk = ~clk;

   fast_slew_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_in(osc_in),
      .range_eff(range_eff)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called just after a falling edge; returns just after the next falling edge
   task automatic wr_reg(input logic a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // toggle osc_in, then sample at each falling edge
   task automatic measure(input int maxc, output int first, output int len);
      first = -1; len = 0;
      osc_in = ~osc_in;
      for (int i = 1; i <= maxc; i++) begin
         @(negedge clk);
         if (range_eff == 2'b11) begin
            if (first < 0) first = i;
            len++;
         end
      end
   endtask

   task automatic t_reset;
      logic [7:0] d;
      rd_reg(1'b0, d); chk(d == 8'h00, "R1 ctrl reset", d, 0);
      rd_reg(1'b1, d); chk(d == 8'h00, "R1 range reset", d, 0);
      chk(range_eff == 2'b00, "R1 range_eff reset", range_eff, 0);
   endtask

   task automatic t_readback;
      logic [7:0] d;
      wr_reg(1'b0, 8'hA7);
      rd_reg(1'b0, d); chk(d == 8'hA7, "R2 ctrl readback", d, 8'hA7);
      wr_reg(1'b1, 8'hFE);
      rd_reg(1'b1, d); chk(d == 8'h02, "R2 range readback masked", d, 2);
      wr_reg(1'b1, {6'd0, USR});
      wr_reg(1'b0, 8'h00);
   endtask

   task automatic t_disabled;
      int f, l;
      wr_reg(1'b0, {7'd9, 1'b0});
      measure(20, f, l);
      chk(l == 0, "R7 no override when disabled (rise)", l, 0);
      measure(20, f, l);
      chk(l == 0, "R7 no override when disabled (fall)", l, 0);
      chk(range_eff == USR, "R7 output equals user", range_eff, USR);
   endtask

   task automatic t_basic;
      int f, l;
      logic [7:0] d;
      wr_reg(1'b0, {7'd5, 1'b1});
      measure(15, f, l);
      chk(f == 3, "R3 rising override start", f, 3);
      chk(l == 5, "R3 rising override length", l, 5);
      chk(range_eff == USR, "R5 return to user", range_eff, USR);
      wr_reg(1'b0, {7'd3, 1'b1});
      osc_in = ~osc_in;
      repeat (4) @(negedge clk);
      chk(range_eff == 2'b11, "R4 falling override active", range_eff, 3);
      rd_reg(1'b1, d); chk(d == {6'd0, USR}, "R8 readback during override", d, USR);
      repeat (4) @(negedge clk);
      chk(range_eff == USR, "R5 return after falling interval", range_eff, USR);
      measure(12, f, l);
      chk(f == 3 && l == 3, "R4 edge-to-edge length", l, 3);
   endtask

   task automatic t_zero;
      int f, l;
      wr_reg(1'b0, {7'd0, 1'b1});
      measure(10, f, l);
      chk(l == 0, "R6 zero count no override", l, 0);
   endtask

   task automatic t_retrigger;
      int l = 0;
      wr_reg(1'b0, {7'd10, 1'b1});
      osc_in = ~osc_in;
      for (int i = 1; i <= 30; i++) begin
         @(negedge clk);
         if (range_eff == 2'b11) l++;
         if (i == 6) osc_in = ~osc_in;
      end
      chk(l == 16, "R9 retrigger reloads full count", l, 16);
   endtask

   task automatic t_disable_mid;
      int l = 0;
      wr_reg(1'b0, {7'd20, 1'b1});
      osc_in = ~osc_in;
      repeat (5) @(negedge clk);
      chk(range_eff == 2'b11, "R10 override active before clear", range_eff, 3);
      wr_reg(1'b0, {7'd20, 1'b0});
      chk(range_eff == USR, "R10 released after disable write", range_eff, USR);
      wr_reg(1'b0, {7'd20, 1'b1});
      for (int i = 0; i < 25; i++) begin
         @(negedge clk);
         if (range_eff == 2'b11) l++;
      end
      chk(l == 0, "R10 counter cleared, no resume", l, 0);
   endtask

   task automatic t_cnt_change;
      int l = 0, f, l2;
      wr_reg(1'b0, {7'd8, 1'b1});
      osc_in = ~osc_in;
      for (int i = 1; i <= 20; i++) begin
         if (i == 6) begin
            bus_addr = 1'b0; bus_wdata = {7'd2, 1'b1}; bus_wr = 1'b1;
         end
         @(negedge clk);
         bus_wr = 1'b0;
         if (range_eff == 2'b11) l++;
      end
      chk(l == 8, "R11 in-flight interval unchanged", l, 8);
      measure(10, f, l2);
      chk(l2 == 2, "R11 next edge uses new count", l2, 2);
   endtask

   task automatic t_max;
      int f, l;
      wr_reg(1'b0, {7'd127, 1'b1});
      measure(140, f, l);
      chk(f == 3 && l == 127, "R12 maximum interval", l, 127);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_readback;
      t_disabled;
      t_basic;
      t_zero;
      t_retrigger;
      t_disable_mid;
      t_cnt_change;
      t_max;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule